// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock Output

This block is a general-purpose timer/counter built from a counter register and a reload register of equal width. In timer mode it advances once for each cycle in which the tick input is high. In counter mode it advances once for each falling edge seen on an external count pin. When the counter wraps, it restarts from the reload value. An optional up/down mode takes the counting direction from a second external pin. When counting down, the underflow point is the reload value, and the counter then restarts from all-ones. A clock-output mode turns the reload events into a square wave on an output pin.

Software controls the block through plain configuration bits, write strobes for the counter and the reload register, and clear strobes for the two sticky flags. Both external pins pass through a synchronizer before they are used. A falling edge is detected by comparing the synchronized level with its value one cycle earlier.

Top module: `updn_timer`

## Requirements
- R1: While `runEn` is low, the counter does not change, except through a software load.
- R2: In timer mode (`ctrSel` low), each cycle with `tick` high advances the counter by one, visible after that clock edge.
- R3: In counter mode (`ctrSel` high), `tick` is ignored. Each falling edge of `cntPin` advances the counter by one, after a synchronizer of `SYNC_STAGES` flops plus one edge-detect flop.
- R4: With `downEn` and `outEn` low, a step taken from all-ones loads the reload value and sets `ovfFlag`. `extFlag` is not touched.
- R5: With `downEn` high, `outEn` low and the synchronized `extPin` high, the counter counts up. A step from all-ones loads the reload value, sets `ovfFlag` and inverts `extFlag`.
- R6: With `downEn` high, `outEn` low and the synchronized `extPin` low, the counter counts down. A step whose decremented value would equal the reload value instead loads all-ones, sets `ovfFlag` and inverts `extFlag`.
- R7: With `outEn` high, the counter counts up and reloads on wrap without setting `ovfFlag`. Each such reload inverts `clkOut` only when `ctrSel` is low.
- R8: With `outEn` high, a synchronized falling edge on `extPin` sets `extFlag` only when `extEn` is high. This holds whether or not `runEn` is high.
- R9: `ovfFlag` and `extFlag` stay set until `clrOvf` or `clrExt` is pulsed. A hardware event in the same cycle is applied after the clear.
- R10: While `capSel` is high, no counting step is taken.
- R11: `ldCount` writes `wrData` into the counter and takes priority over counting. `ldReload` writes `wrData` into the reload register.
- R12: After reset, the counter, the reload register, both flags and `clkOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable |
| ctrSel | input | 1 | 1: count pin edges, 0: count ticks |
| capSel | input | 1 | Reload/capture select; high halts counting |
| extEn | input | 1 | Lets extPin falls set extFlag in clock-out mode |
| downEn | input | 1 | Up/down mode enable |
| outEn | input | 1 | Clock-output mode enable |
| tick | input | 1 | Timer-mode count enable |
| cntPin | input | 1 | External count pin (asynchronous) |
| extPin | input | 1 | External direction/event pin (asynchronous) |
| ldCount | input | 1 | Load counter from wrData |
| ldReload | input | 1 | Load reload register from wrData |
| wrData | input | WIDTH | Software write data |
| clrOvf | input | 1 | Clear ovfFlag |
| clrExt | input | 1 | Clear extFlag |
| count | output | WIDTH | Current counter value |
| ovfFlag | output | 1 | Sticky overflow/underflow flag |
| extFlag | output | 1 | Sticky external flag |
| clkOut | output | 1 | Clock-output pin |

## Verification
The bench builds the block with `WIDTH` set to 8 and `SYNC_STAGES` left at 2. The narrow counter brings wrap, underflow and back-to-back reload sequences within a handful of ticks. Starting values are placed just below the boundaries with software loads. Keeping the synchronizer depth at its default pins the pin-to-count latency to a fixed number of cycles, which the edge-driven tests wait out before they check.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic step;        // take a normal count step
    logic down;        // direction of that step
    logic loadReload;  // counter <= reload register
    logic loadAllOnes; // counter <= all ones
    logic setOvf;
    logic toggleExt;
    logic setExt;
    logic toggleOut;
  } tmrStrobe_t;

endpackage

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prevQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= pinIn;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], pinIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= chain[LAST];

  assign level = chain[LAST];
  assign fall  = prevQ & ~chain[LAST];
endmodule

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
(
  input  logic       runEn,
  input  logic       ctrSel,
  input  logic       capSel,
  input  logic       extEn,
  input  logic       downEn,
  input  logic       outEn,
  input  logic       tick,
  input  logic       cntFall,
  input  logic       extLevel,
  input  logic       extFall,
  input  logic       atAllOnes,
  input  logic       hitReload,
  output tmrStrobe_t strb
);
  logic advance;

  always_comb begin
    advance = runEn & ~capSel & (ctrSel ? cntFall : tick);
    strb    = '0;
    if (outEn) begin
      strb.setExt = extEn & extFall;
      if (advance) begin
        if (atAllOnes) begin
          strb.loadReload = 1'b1;
          strb.toggleOut  = ~ctrSel;
        end else begin
          strb.step = 1'b1;
        end
      end
    end else if (downEn) begin
      if (advance) begin
        if (extLevel) begin
          if (atAllOnes) begin
            strb.loadReload = 1'b1;
            strb.setOvf     = 1'b1;
            strb.toggleExt  = 1'b1;
          end else begin
            strb.step = 1'b1;
          end
        end else begin
          if (hitReload) begin
            strb.loadAllOnes = 1'b1;
            strb.setOvf      = 1'b1;
            strb.toggleExt   = 1'b1;
          end else begin
            strb.step = 1'b1;
            strb.down = 1'b1;
          end
        end
      end
    end else if (advance) begin
      if (atAllOnes) begin
        strb.loadReload = 1'b1;
        strb.setOvf     = 1'b1;
      end else begin
        strb.step = 1'b1;
      end
    end
  end
endmodule

// File: rtl/updn_timer_dp.sv
module updn_timer_dp
  import updn_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             ldCount,
  input  logic             ldReload,
  input  logic [WIDTH-1:0] wrData,
  input  logic             clrOvf,
  input  logic             clrExt,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             clkOut,
  output logic             atAllOnes,
  output logic             hitReload
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] reloadQ;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] countNext;

  assign decVal    = count - ONE;
  assign atAllOnes = (count == ALL_ONES);
  assign hitReload = (decVal == reloadQ);

  always_comb begin
    if (ldCount)               countNext = wrData;
    else if (strb.loadReload)  countNext = reloadQ;
    else if (strb.loadAllOnes) countNext = ALL_ONES;
    else if (strb.step)        countNext = strb.down ? decVal : count + ONE;
    else                       countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      reloadQ <= '0;
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
      clkOut  <= 1'b0;
    end else begin
      count   <= countNext;
      if (ldReload) reloadQ <= wrData;
      ovfFlag <= strb.setOvf | (ovfFlag & ~clrOvf);
      extFlag <= strb.setExt | ((extFlag & ~clrExt) ^ strb.toggleExt);
      clkOut  <= clkOut ^ strb.toggleOut;
    end
  end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             ctrSel,
  input  logic             capSel,
  input  logic             extEn,
  input  logic             downEn,
  input  logic             outEn,
  input  logic             tick,
  input  logic             cntPin,
  input  logic             extPin,
  input  logic             ldCount,
  input  logic             ldReload,
  input  logic [WIDTH-1:0] wrData,
  input  logic             clrOvf,
  input  logic             clrExt,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             clkOut
);
  tmrStrobe_t strb;
  logic cntLevel, cntFall, extLevel, extFall, atAllOnes, hitReload;

  pin_fall_detect #(.STAGES(SYNC_STAGES)) u_cntSync (
    .clk(clk), .rstN(rstN), .pinIn(cntPin), .level(cntLevel), .fall(cntFall));

  pin_fall_detect #(.STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .pinIn(extPin), .level(extLevel), .fall(extFall));

  updn_timer_ctrl u_ctrl (
    .runEn(runEn), .ctrSel(ctrSel), .capSel(capSel), .extEn(extEn),
    .downEn(downEn), .outEn(outEn), .tick(tick), .cntFall(cntFall),
    .extLevel(extLevel), .extFall(extFall), .atAllOnes(atAllOnes),
    .hitReload(hitReload), .strb(strb));

  updn_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldCount(ldCount),
    .ldReload(ldReload), .wrData(wrData), .clrOvf(clrOvf), .clrExt(clrExt),
    .count(count), .ovfFlag(ovfFlag), .extFlag(extFlag), .clkOut(clkOut),
    .atAllOnes(atAllOnes), .hitReload(hitReload));

  logic unusedCntLevel;
  assign unusedCntLevel = cntLevel;
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             ctrSel,
  input logic             capSel,
  input logic             extEn,
  input logic             downEn,
  input logic             outEn,
  input logic             tick,
  input logic             cntPin,
  input logic             extPin,
  input logic             ldCount,
  input logic             ldReload,
  input logic [WIDTH-1:0] wrData,
  input logic             clrOvf,
  input logic             clrExt,
  input logic [WIDTH-1:0] count,
  input logic             ovfFlag,
  input logic             extFlag,
  input logic             clkOut
);
  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !ldCount) |=> $stable(count));

  a_r10_hold_when_capsel: assert property (@(posedge clk) disable iff (!rstN)
    (capSel && !ldCount) |=> $stable(count));

  a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !capSel && !ctrSel && !outEn && !downEn && tick && !ldCount && (&count))
    |=> ovfFlag);

  a_r7_clkout_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkOut) |-> ($past(outEn) && !$past(ctrSel) && $past(runEn)));

  a_r7_ovf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(runEn) && !$past(outEn)));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag);
endmodule

bind updn_timer updn_timer_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/updn_timer_bench.sv
module updn_timer_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, ctrSel = 0, capSel = 0, extEn = 0, downEn = 0, outEn = 0;
  logic tick = 0, cntPin = 1, extPin = 1;
  logic ldCount = 0, ldReload = 0, clrOvf = 0, clrExt = 0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic ovfFlag, extFlag, clkOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  updn_timer #(.WIDTH(W), .SYNC_STAGES(2)) u_updn_timer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .ctrSel(ctrSel), .capSel(capSel),
    .extEn(extEn), .downEn(downEn), .outEn(outEn), .tick(tick),
    .cntPin(cntPin), .extPin(extPin), .ldCount(ldCount), .ldReload(ldReload),
    .wrData(wrData), .clrOvf(clrOvf), .clrExt(clrExt), .count(count),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .clkOut(clkOut));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic loadCnt(input logic [W-1:0] v);
    wrData = v; ldCount = 1; @(negedge clk); ldCount = 0;
  endtask

  task automatic loadRel(input logic [W-1:0] v);
    wrData = v; ldReload = 1; @(negedge clk); ldReload = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask

  task automatic clearFlags();
    clrOvf = 1; clrExt = 1; @(negedge clk); clrOvf = 0; clrExt = 0;
  endtask

  task automatic cntPulse();
    cntPin = 0; repeat (4) @(negedge clk);
    cntPin = 1; repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R12 count", count, 0);
    check("R12 ovf", ovfFlag, 0);
    check("R12 ext", extFlag, 0);
    check("R12 clkOut", clkOut, 0);
  endtask

  task automatic testStopped();
    loadCnt(8'h10);
    check("R11 load", count, 8'h10);
    runEn = 0; ticks(5);
    check("R1 stopped", count, 8'h10);
  endtask

  task automatic testTimer();
    runEn = 1; ticks(5);
    check("R2 tick count", count, 8'h15);
  endtask

  task automatic testWrap();
    loadRel(8'h40); loadCnt(8'hFE); ticks(1);
    check("R2 to FF", count, 8'hFF);
    check("R4 no ovf yet", ovfFlag, 0);
    ticks(1);
    check("R4 reload", count, 8'h40);
    check("R4 ovf set", ovfFlag, 1);
    check("R4 ext untouched", extFlag, 0);
    repeat (3) @(negedge clk);
    check("R9 ovf sticky", ovfFlag, 1);
    clearFlags();
    check("R9 ovf cleared", ovfFlag, 0);
  endtask

  task automatic testCounter();
    ctrSel = 1; loadCnt(8'h05);
    ticks(4);
    check("R3 tick ignored", count, 8'h05);
    repeat (3) cntPulse();
    check("R3 edge count", count, 8'h08);
    ctrSel = 0;
  endtask

  task automatic testUpDown();
    downEn = 1; extPin = 1; repeat (4) @(negedge clk);
    loadRel(8'h20); loadCnt(8'hFF); ticks(1);
    check("R5 reload", count, 8'h20);
    check("R5 ovf", ovfFlag, 1);
    check("R5 ext toggled", extFlag, 1);
    ticks(1);
    check("R5 up step", count, 8'h21);
    clearFlags();
    extPin = 0; repeat (4) @(negedge clk);
    loadCnt(8'h22); ticks(1);
    check("R6 down step", count, 8'h21);
    check("R6 no ovf", ovfFlag, 0);
    ticks(1);
    check("R6 underflow load", count, 8'hFF);
    check("R6 ovf", ovfFlag, 1);
    check("R6 ext toggled", extFlag, 1);
    ticks(1);
    check("R6 keeps down", count, 8'hFE);
    downEn = 0; extPin = 1; clearFlags();
    repeat (4) @(negedge clk);
  endtask

  task automatic testClockOut();
    outEn = 1; loadRel(8'hFC); loadCnt(8'hFE);
    ticks(2);
    check("R7 reload", count, 8'hFC);
    check("R7 clkOut high", clkOut, 1);
    check("R7 no ovf", ovfFlag, 0);
    ticks(4);
    check("R7 second reload", count, 8'hFC);
    check("R7 clkOut low", clkOut, 0);
    ctrSel = 1; loadCnt(8'hFF); cntPulse();
    check("R7 counter reload", count, 8'hFC);
    check("R7 counter no toggle", clkOut, 0);
    ctrSel = 0;
  endtask

  task automatic testExtEdge();
    runEn = 0; extEn = 1;
    extPin = 0; repeat (4) @(negedge clk);
    check("R8 ext set", extFlag, 1);
    extPin = 1; clearFlags(); extEn = 0; repeat (3) @(negedge clk);
    extPin = 0; repeat (4) @(negedge clk);
    check("R8 ext disabled", extFlag, 0);
    extPin = 1; outEn = 0; repeat (3) @(negedge clk);
  endtask

  task automatic testCapSel();
    runEn = 1; capSel = 1; loadCnt(8'h30); ticks(4);
    check("R10 halted", count, 8'h30);
    capSel = 0; ticks(1);
    check("R10 resumes", count, 8'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testStopped();
    testTimer();
    testWrap();
    testCounter();
    testUpDown();
    testClockOut();
    testExtEdge();
    testCapSel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule